// File: doc/BRIEF.md
# Backend Stage Flow Controller

This block sequences one backend pipeline stage through five control states: Idle, Running, Blocked, Unblocking and Squashing. It watches a stall request and two squash flags from the downstream commit stage, plus a full flag from the instruction queue. From these it decides whether instruction groups arriving from the upstream rename stage are dispatched at once, or parked in an internal skid buffer. It also decides when the stage stalls rename and when the squash machinery is started, continued or stopped.

While the stage is blocked, each arriving group is written whole into a small FIFO. Once the block is released, that FIFO is replayed oldest-first, one group per cycle. Rename stays stalled until the buffer is almost empty. A squash empties the buffer. The squash state is held for as long as either of the two squash flags stays high. Every cycle, the instruction queue's free-entry count is passed back to rename with one register of delay. The instruction queue, the load/store queue and the squash walk itself live outside this block, which only issues the three squash pulses.

Top module: `stage_flow_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `state_o` is 0 (Idle), and the stall, dispatch, squash pulse and overflow outputs are all low.
- R2: State codes are Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4. In Idle, a cycle with no valid group, no stall and no squash flag keeps Idle. Any one of those inputs is handled as in Running, and the default next state is Running.
- R3: In Running, Idle or Unblocking, a commit stall takes priority over everything else. The state becomes Blocked, and a valid group arriving that cycle is written to the skid buffer. Otherwise, if either squash flag is high, the state becomes Squashing.
- R4: In Running or active Idle, with no stall, no squash and the queue not full, a valid group is presented on the dispatch output in the next cycle. If the queue is full, the state becomes Blocked and the group is written to the skid buffer.
- R5: In Blocked, `rename_stall_o` is high and every valid group is written to the skid buffer. With both squash flags low, the commit stall low and the queue not full, the next state is Unblocking.
- R6: In Unblocking, with no stall, no squash and the queue not full, one group is read from the skid buffer per cycle, oldest first, and appears on the dispatch output in the next cycle. A new valid group is appended to the buffer. The state returns to Running when the buffer would be empty. `rename_stall_o` is high while the buffer holds more than one group. If the queue is full, the state becomes Blocked and no group is read.
- R7: A squash flag seen in Blocked moves the state to Squashing. Entering Squashing from any state empties the skid buffer, and `start_squash_o` is high during the first Squashing cycle.
- R8: In Squashing, if either squash flag is high, the state stays and `cont_squash_o` pulses in the next cycle. If both are low, the state becomes Running and `stop_squash_o` pulses in the next cycle. At most one of the three squash pulses is high in any cycle.
- R9: A write to a full skid buffer with no read in the same cycle drops the group and sets `overflow_o`, which stays high until reset.
- R10: `free_to_rename_o` equals the value of `iq_free_i` from the previous cycle, in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_valid_i | input | 1 | Group from rename is valid |
| grp_data_i | input | GROUP_W | Group payload from rename |
| commit_stall_i | input | 1 | Stall request from commit |
| commit_squash_i | input | 1 | Squash flag from commit |
| rob_squash_i | input | 1 | Reorder buffer squashing flag |
| iq_full_i | input | 1 | Instruction queue full |
| iq_free_i | input | FREE_W | Free instruction queue entries |
| rename_stall_o | output | 1 | Stall to rename |
| free_to_rename_o | output | FREE_W | Registered free entry count |
| disp_valid_o | output | 1 | Dispatched group valid |
| disp_data_o | output | GROUP_W | Dispatched group payload |
| start_squash_o | output | 1 | Start-squash pulse |
| cont_squash_o | output | 1 | Continue-squash pulse |
| stop_squash_o | output | 1 | Stop-squash pulse |
| state_o | output | 3 | Current state code |
| overflow_o | output | 1 | Sticky skid overflow |

## Verification
The first phase applies every ordered pair of the 32 combinations of valid, stall, the two squash flags and queue-full, one pair after another. It therefore reaches every state under every input. Because the stall, squash and full flags are then high most of the time, this phase mostly shows which of them wins in each state. A second, pseudo-random phase keeps the stall and full flags high for long stretches and squashes rarely. This fills the skid buffer up to overflow and then drains it, which separates correct oldest-first replay and correct stall release from reordering, lost groups or a drain that ends one entry early. Each payload is a rising counter, so a dropped or duplicated group is visible at the dispatch output.

// File: rtl/stage_flow_pkg.sv
// Package: shared state encoding for the stage flow controller.
// Assumes: the codes are observed outside the block, so their values are fixed.
package stage_flow_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_BLOCKED = 3'd2,
        ST_UNBLOCK = 3'd3,
        ST_SQUASH  = 3'd4
    } flow_state_e;
endpackage

// File: rtl/stage_skid_fifo.sv
// Module: skid FIFO holding whole instruction groups.
// A flush empties it and takes priority over push and pop. A push into a full
// FIFO with no pop in the same cycle is dropped and flagged.
// Assumes: the caller never pops an empty FIFO (it is guarded anyway).
module stage_skid_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic                         flush,
    input  logic [W-1:0]                 wdata,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         drop
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          do_pop, do_push, full;

    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && (count != '0) && !flush;
    assign do_push = push && !flush && (!full || do_pop);
    assign drop    = push && !flush && full && !do_pop;
    assign rdata   = mem[rd_ptr];

    // Wrap a pointer at DEPTH, which need not be a power of two.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push) wr_ptr <= bump(wr_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write, one slot per entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && wr_ptr == PW'(i)) mem[i] <= wdata;
        end
    end
endmodule

// File: rtl/stage_flow_fsm.sv
// Module: state register and next-state decisions for the stage.
// Each cycle it decides whether the arriving group is dispatched directly,
// parked, or discarded. It also decides whether the skid head is replayed
// and which squash pulse fires.
// Assumes: skid count comes from stage_skid_fifo in the same cycle.
module stage_flow_fsm
    import stage_flow_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grp_valid,
    input  logic          stall_req,
    input  logic          squash_any,
    input  logic          iq_full,
    input  logic [CW-1:0] skid_cnt,
    output flow_state_e   state,
    output logic          push,
    output logic          pop,
    output logic          flush,
    output logic          direct,
    output logic          start_p,
    output logic          cont_p,
    output logic          stop_p
);
    flow_state_e nstate;
    logic        active;
    logic        empties;

    // Whether the normal run checks apply this cycle.
    assign active = (state == ST_RUN) || (state == ST_UNBLOCK) ||
                    ((state == ST_IDLE) && (grp_valid || stall_req || squash_any));

    // Replay leaves nothing behind when at most the popped entry was held.
    assign empties = !grp_valid && ((skid_cnt == '0) || (skid_cnt == CW'(1)));

    // Next-state and action decode.
    always_comb begin
        nstate  = state;
        push    = 1'b0;
        pop     = 1'b0;
        flush   = 1'b0;
        direct  = 1'b0;
        start_p = 1'b0;
        cont_p  = 1'b0;
        stop_p  = 1'b0;
        if (active) begin
            if (stall_req) begin
                nstate = ST_BLOCKED;
                push   = grp_valid;
            end else if (squash_any) begin
                nstate  = ST_SQUASH;
                flush   = 1'b1;
                start_p = 1'b1;
            end else if (iq_full && (grp_valid || state == ST_UNBLOCK)) begin
                nstate = ST_BLOCKED;
                push   = grp_valid;
            end else if (state == ST_UNBLOCK) begin
                pop    = (skid_cnt != '0);
                push   = grp_valid;
                nstate = empties ? ST_RUN : ST_UNBLOCK;
            end else begin
                direct = grp_valid;
                nstate = ST_RUN;
            end
        end else if (state == ST_BLOCKED) begin
            if (squash_any) begin
                nstate  = ST_SQUASH;
                flush   = 1'b1;
                start_p = 1'b1;
            end else begin
                push = grp_valid;
                if (!stall_req && !iq_full) nstate = ST_UNBLOCK;
            end
        end else if (state == ST_SQUASH) begin
            if (squash_any) begin
                cont_p = 1'b1;
            end else begin
                nstate = ST_RUN;
                stop_p = 1'b1;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end
endmodule

// File: rtl/stage_flow_ctrl.sv
// Module: top of the stage flow controller.
// It joins the decision FSM and the skid FIFO and registers the dispatch,
// pulse and free-count outputs. The stall to rename is decoded from state and
// skid occupancy.
// Assumes: rename honours rename_stall_o. Groups it sends anyway are still
// parked in the skid buffer, or dropped while squashing.
module stage_flow_ctrl
    import stage_flow_pkg::*;
#(
    parameter int GROUP_W    = 16,
    parameter int SKID_DEPTH = 4,
    parameter int FREE_W     = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grp_valid_i,
    input  logic [GROUP_W-1:0] grp_data_i,
    input  logic               commit_stall_i,
    input  logic               commit_squash_i,
    input  logic               rob_squash_i,
    input  logic               iq_full_i,
    input  logic [FREE_W-1:0]  iq_free_i,
    output logic               rename_stall_o,
    output logic [FREE_W-1:0]  free_to_rename_o,
    output logic               disp_valid_o,
    output logic [GROUP_W-1:0] disp_data_o,
    output logic               start_squash_o,
    output logic               cont_squash_o,
    output logic               stop_squash_o,
    output logic [2:0]         state_o,
    output logic               overflow_o
);
    localparam int CW = $clog2(SKID_DEPTH+1);

    flow_state_e        state;
    logic               push, pop, flush, direct;
    logic               start_p, cont_p, stop_p, drop;
    logic [CW-1:0]      skid_cnt;
    logic [GROUP_W-1:0] skid_head;

    stage_flow_fsm #(.CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_valid  (grp_valid_i),
        .stall_req  (commit_stall_i),
        .squash_any (commit_squash_i || rob_squash_i),
        .iq_full    (iq_full_i),
        .skid_cnt   (skid_cnt),
        .state      (state),
        .push       (push),
        .pop        (pop),
        .flush      (flush),
        .direct     (direct),
        .start_p    (start_p),
        .cont_p     (cont_p),
        .stop_p     (stop_p)
    );

    stage_skid_fifo #(.W(GROUP_W), .DEPTH(SKID_DEPTH)) u_skid (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .flush (flush),
        .wdata (grp_data_i),
        .rdata (skid_head),
        .count (skid_cnt),
        .drop  (drop)
    );

    // Stall rename while blocked, or while more than the popped group remains.
    assign rename_stall_o = (state == ST_BLOCKED) ||
                            ((state == ST_UNBLOCK) && (skid_cnt > CW'(1)));
    assign state_o = state;

    // Registered dispatch, pulse, overflow and free-count outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_valid_o     <= 1'b0;
            disp_data_o      <= '0;
            start_squash_o   <= 1'b0;
            cont_squash_o    <= 1'b0;
            stop_squash_o    <= 1'b0;
            overflow_o       <= 1'b0;
            free_to_rename_o <= '0;
        end else begin
            disp_valid_o     <= direct || pop;
            disp_data_o      <= direct ? grp_data_i : skid_head;
            start_squash_o   <= start_p;
            cont_squash_o    <= cont_p;
            stop_squash_o    <= stop_p;
            overflow_o       <= overflow_o || drop;
            free_to_rename_o <= iq_free_i;
        end
    end
endmodule

// File: rtl/stage_flow_chk.sv
// Module: property checker for stage_flow_ctrl, bound to every instance.
// Assumes: the state codes of stage_flow_pkg.
module stage_flow_chk #(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    state_o,
    input logic          rename_stall_o,
    input logic          overflow_o,
    input logic          start_squash_o,
    input logic          cont_squash_o,
    input logic          stop_squash_o,
    input logic          commit_stall_i,
    input logic          commit_squash_i,
    input logic          rob_squash_i,
    input logic          iq_full_i,
    input logic [CW-1:0] skid_cnt
);
    // R5
    blocked_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd2 |-> rename_stall_o);
    // R5
    unblock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && !commit_squash_i && !rob_squash_i && !commit_stall_i && !iq_full_i)
        |=> state_o == 3'd3);
    // R6
    drain_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && skid_cnt > CW'(1)) |-> rename_stall_o);
    // R7
    start_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_squash_o |-> (state_o == 3'd4 && skid_cnt == '0));
    // R8
    stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_squash_o |-> (state_o == 3'd1 && $past(state_o) == 3'd4));
    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_squash_o, cont_squash_o, stop_squash_o}));
    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);
endmodule

bind stage_flow_ctrl stage_flow_chk #(.CW(CW)) u_flow_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .state_o         (state_o),
    .rename_stall_o  (rename_stall_o),
    .overflow_o      (overflow_o),
    .start_squash_o  (start_squash_o),
    .cont_squash_o   (cont_squash_o),
    .stop_squash_o   (stop_squash_o),
    .commit_stall_i  (commit_stall_i),
    .commit_squash_i (commit_squash_i),
    .rob_squash_i    (rob_squash_i),
    .iq_full_i       (iq_full_i),
    .skid_cnt        (skid_cnt)
);

// File: tb/stage_flow_ctrl_bench.sv
module stage_flow_ctrl_bench;
    localparam int GW = 16;
    localparam int D  = 4;
    localparam int FW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          v = 0, st = 0, sq = 0, rb = 0, fu = 0;
    logic [GW-1:0] data = '0;
    logic [FW-1:0] free = '0;
    logic          stall_o, dv_o, start_o, cont_o, stop_o, ovf_o;
    logic [FW-1:0] free_o;
    logic [GW-1:0] dd_o;
    logic [2:0]    state_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Model of the requirements.
    int            m_s;
    logic [GW-1:0] m_q[$];
    bit            m_ovf, m_dv, m_start, m_cont, m_stop, m_fromskid;
    logic [GW-1:0] m_dd;
    logic [FW-1:0] m_free;

    always #10 clk = ~clk;

    stage_flow_ctrl #(.GROUP_W(GW), .SKID_DEPTH(D), .FREE_W(FW)) u_stage_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .grp_valid_i(v), .grp_data_i(data),
        .commit_stall_i(st), .commit_squash_i(sq), .rob_squash_i(rb),
        .iq_full_i(fu), .iq_free_i(free), .rename_stall_o(stall_o),
        .free_to_rename_o(free_o), .disp_valid_o(dv_o), .disp_data_o(dd_o),
        .start_squash_o(start_o), .cont_squash_o(cont_o), .stop_squash_o(stop_o),
        .state_o(state_o), .overflow_o(ovf_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model one cycle with the inputs currently driven.
    task automatic model_step();
        bit sqa, active, push, pop, flush, dir;
        int ns;
        sqa = sq | rb; ns = m_s;
        push = 0; pop = 0; flush = 0; dir = 0;
        m_start = 0; m_cont = 0; m_stop = 0;
        active = (m_s == 1) || (m_s == 3) || (m_s == 0 && (v || st || sqa));
        if (active) begin
            if (st) begin ns = 2; push = v; end                        // R3
            else if (sqa) begin ns = 4; flush = 1; m_start = 1; end
            else if (fu && (v || m_s == 3)) begin ns = 2; push = v; end // R4
            else if (m_s == 3) begin                                    // R6
                pop = (m_q.size() > 0); push = v;
                ns = (m_q.size() - int'(pop) + int'(push) == 0) ? 1 : 3;
            end else begin dir = v; ns = 1; end
        end else if (m_s == 2) begin
            if (sqa) begin ns = 4; flush = 1; m_start = 1; end          // R7
            else begin push = v; if (!st && !fu) ns = 3; end
        end else if (m_s == 4) begin                                    // R8
            if (sqa) m_cont = 1; else begin ns = 1; m_stop = 1; end
        end
        m_dv = dir || pop;
        m_fromskid = pop;
        if (dir) m_dd = data; else if (pop) m_dd = m_q[0];
        if (flush) m_q.delete();
        else begin
            if (pop) void'(m_q.pop_front());
            if (push) begin
                if (m_q.size() == D) m_ovf = 1;                         // R9
                else m_q.push_back(data);
            end
        end
        m_free = free;
        m_s = ns;
    endtask

    task automatic cycle(input bit iv, input bit ist, input bit isq, input bit irb,
                         input bit ifu);
        @(negedge clk);
        v = iv; st = ist; sq = isq; rb = irb; fu = ifu;
        data = data + 1'b1;
        free = free + 3'd5;
        model_step();
        @(posedge clk);
        #2;
        chk("R3 state", int'(state_o), m_s);
        chk("R5 rename stall", int'(stall_o), int'(m_s == 2 || (m_s == 3 && m_q.size() > 1)));
        chk(m_fromskid ? "R6 dispatch valid" : "R4 dispatch valid", int'(dv_o), int'(m_dv));
        if (m_dv) chk(m_fromskid ? "R6 dispatch data" : "R4 dispatch data", int'(dd_o), int'(m_dd));
        chk("R7 start pulse", int'(start_o), int'(m_start));
        chk("R8 continue pulse", int'(cont_o), int'(m_cont));
        chk("R8 stop pulse", int'(stop_o), int'(m_stop));
        chk("R9 overflow", int'(ovf_o), int'(m_ovf));
        chk("R10 free count", int'(free_o), int'(m_free));
    endtask

    initial begin
        logic [15:0] lfsr;
        m_s = 0; m_ovf = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset values
        chk("R1 state", int'(state_o), 0);
        chk("R1 stall", int'(stall_o), 0);
        chk("R1 dispatch", int'(dv_o), 0);
        chk("R1 pulses", int'({start_o, cont_o, stop_o}), 0);
        chk("R1 overflow", int'(ovf_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 idle with no activity stays idle
        for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, 0);
        chk("R2 idle hold", int'(state_o), 0);
        // R2 first group leaves idle
        cycle(1, 0, 0, 0, 0);
        chk("R2 idle exit", int'(state_o), 1);
        // Directed fill to overflow, then drain (R5, R6, R9)
        for (int i = 0; i < 6; i++) cycle(1, 1, 0, 0, 0);
        chk("R9 overflow after fill", int'(ovf_o), 1);
        for (int i = 0; i < 6; i++) cycle(0, 0, 0, 0, 0);
        chk("R6 drained to running", int'(state_o), 1);
        // Pairwise sweep of all input combinations
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                cycle(a[0], a[1], a[2], a[3], a[4]);
                cycle(b[0], b[1], b[2], b[3], b[4]);
            end
        end
        // Reset clears sticky overflow before the random phase
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_s = 0; m_ovf = 0; m_q.delete();
        #1 chk("R1 overflow cleared", int'(ovf_o), 0);
        // Biased pseudo-random phase: long stalls, rare squashes
        lfsr = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(lfsr[0] | lfsr[1], (lfsr[4:2] != 0) && lfsr[9], lfsr[8:5] == 0,
                  lfsr[12:9] == 4'hF, lfsr[14] & lfsr[11]);
        end
        done = 1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule